// File: doc/BRIEF.md
# CPU Exception Source Detector

This block sits beside the decode and execute stages of a small 32-bit CPU core. It watches the reset pins, the debug reset commands, the watchdog, the register-bank save machinery and the decoded instruction, and raises exception requests to the pipeline sequencer. Each request is a one-cycle pulse with a 3-bit type code. When several sources are live in the same cycle, only the most urgent one is reported.

Instruction exceptions are latched when the instruction is decoded. They are released only once the execute stage reports that the previous instruction has finished. Resets and bank overflow are reported without waiting. An internal counter tracks how many register banks hold a saved context. Restoring with no save raises an underflow. Saving into a full bank set raises an overflow, but only when software has enabled that check. Any request flushes the instruction exceptions still waiting.

Top module: `excSourceUnit`

## Requirements
- R1: A low-to-high change of `porPin` makes `excReq` high one clock later with `excCode` 0 (power-on reset).
- R2: `dbgRstNegate` raises a power-on request (code 0) on the next clock only if `dbgRstAssert` was seen in an earlier cycle since the last power-on request; a negate with no prior assert is ignored.
- R3: A low-to-high change of `manPin` raises a request with code 1 (manual reset) one clock later.
- R4: `wdtOvf` raises a request on the next clock: code 0 when `wdtManual` is 0, code 1 when `wdtManual` is 1.
- R5: With `intAccept` and `intUsesBank` high, a request with code 6 (bank overflow) is raised on the next clock only when all `NBANKS` banks are already saved and `bankOvfEn` is 1; otherwise no request results.
- R6: The saved-bank count rises by one on each accepted bank-using interrupt, saturating at `NBANKS`. It falls by one on each restore decoded outside a delay slot and is cleared by any reset request. A restore decoded outside a slot while the count is zero raises code 5 (bank underflow).
- R7: In a delay slot (`decInSlot`=1), an undefined opcode, a PC-writing instruction, a 32-bit instruction, a restore, or a signed or unsigned divide raises code 2 (slot illegal).
- R8: Outside a delay slot, an undefined opcode raises code 3 (general illegal). An FPU opcode counts as undefined while `fpuStandby` is 1 and is legal otherwise.
- R9: A divide outside a slot raises code 4 when the divisor is zero. A signed divide of 0x80000000 by 0xFFFFFFFF also raises code 4. An unsigned divide of those same operands raises nothing.
- R10: A trap instruction outside a slot raises code 7.
- R11: Instruction exceptions (codes 2, 3, 4, 5, 7) are issued two clocks after decode at the earliest. They wait while `exIdle` is 0. A request of any kind discards those still waiting.
- R12: Same-cycle sources resolve in fixed order, most urgent first: 0, 1, 2, 3, 4, 5, 6, 7. `excReq` is a one-cycle pulse per exception, and `excCode` reads 0 whenever `excReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| porPin | input | 1 | Power-on reset pin, acts on its rising edge |
| manPin | input | 1 | Manual reset pin, acts on its rising edge |
| dbgRstAssert | input | 1 | Debug reset-assert command strobe |
| dbgRstNegate | input | 1 | Debug reset-negate command strobe |
| wdtOvf | input | 1 | Watchdog overflow strobe |
| wdtManual | input | 1 | Watchdog reset type: 1 manual, 0 power-on |
| exIdle | input | 1 | Previous instruction has completed execution |
| decValid | input | 1 | Decode-stage instruction valid |
| decInSlot | input | 1 | Instruction sits in a delayed-branch slot |
| decUndef | input | 1 | Opcode is undefined |
| decFpuOp | input | 1 | Opcode is FPU-class |
| fpuStandby | input | 1 | FPU is in standby |
| decPcWrite | input | 1 | Instruction rewrites the PC |
| decWide | input | 1 | Instruction is 32 bits wide |
| decBankRestore | input | 1 | Restore-from-bank instruction |
| decDivS | input | 1 | Signed divide instruction |
| decDivU | input | 1 | Unsigned divide instruction |
| decTrap | input | 1 | Trap instruction |
| divDividend | input | DW | Divide dividend operand |
| divDivisor | input | DW | Divide divisor operand |
| bankOvfEn | input | 1 | Bank overflow exception enable |
| intAccept | input | 1 | Interrupt accepted strobe |
| intUsesBank | input | 1 | Accepted interrupt saves to a register bank |
| excReq | output | 1 | Exception request pulse |
| excCode | output | 3 | Exception type code |

## Verification
The assertions check several behaviours on every cycle. Each reset pin edge turns into the matching request on the next clock. The code stays 0 between requests. An overflow flag appears only when the enable bit is set and a bank-using interrupt has been accepted. No instruction exception leaves while the execute stage is busy. Other behaviours need the bench's scenarios, because they depend on history: the saved-bank depth, its saturation and its clearing by resets, whether a debug negate was preceded by an assert, the split between slot and general illegal cases, and the flushing of waiting exceptions.

// File: rtl/excPkg.sv
package excPkg;
  typedef enum logic [2:0] {
    EXC_POR  = 3'd0,
    EXC_MAN  = 3'd1,
    EXC_SLOT = 3'd2,
    EXC_GEN  = 3'd3,
    EXC_DIV  = 3'd4,
    EXC_UNDF = 3'd5,
    EXC_OVF  = 3'd6,
    EXC_TRAP = 3'd7
  } excCode_e;

  localparam int NUM_SRC = 8;

  // datapath -> control: pending instruction classes plus live bank overflow
  typedef struct packed {
    logic slotIll;
    logic genIll;
    logic divErr;
    logic bankUndf;
    logic trap;
    logic bankOvf;
  } dpFlags_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrBank;
    logic clrPend;
  } ctlStrobe_t;
endpackage

// File: rtl/excDp.sv
module excDp
  import excPkg::*;
#(
  parameter int NBANKS = 15,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic          decValid,
  input  logic          decInSlot,
  input  logic          decUndef,
  input  logic          decFpuOp,
  input  logic          fpuStandby,
  input  logic          decPcWrite,
  input  logic          decWide,
  input  logic          decBankRestore,
  input  logic          decDivS,
  input  logic          decDivU,
  input  logic          decTrap,
  input  logic [DW-1:0] divDividend,
  input  logic [DW-1:0] divDivisor,
  input  logic          bankOvfEn,
  input  logic          intAccept,
  input  logic          intUsesBank,
  output dpFlags_t      flags
);
  localparam int CW = $clog2(NBANKS + 1);
  localparam logic [CW-1:0] FULL = CW'(NBANKS);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic [CW-1:0] bankCnt;
  logic undefEff, isDiv, slotNow, genNow, divNow, undfNow, trapNow;
  logic saveEv, restoreEv, bankFull, bankEmpty;
  logic [4:0] pend;

  assign undefEff  = decUndef | (decFpuOp & fpuStandby);
  assign isDiv     = decDivS | decDivU;
  assign bankFull  = (bankCnt == FULL);
  assign bankEmpty = (bankCnt == '0);

  assign slotNow = decInSlot & (undefEff | decPcWrite | decWide | decBankRestore | isDiv);
  assign genNow  = ~decInSlot & undefEff;
  assign divNow  = ~decInSlot & isDiv &
                   ((divDivisor == '0) |
                    (decDivS & (divDividend == MOST_NEG) & (divDivisor == '1)));
  assign undfNow = ~decInSlot & decBankRestore & bankEmpty;
  assign trapNow = ~decInSlot & decTrap;

  assign saveEv    = intAccept & intUsesBank;
  assign restoreEv = decValid & ~decInSlot & decBankRestore & ~bankEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankCnt <= '0;
    end else if (strobe.clrBank) begin
      bankCnt <= '0;
    end else begin
      unique case ({saveEv & ~bankFull, restoreEv})
        2'b10:   bankCnt <= bankCnt + 1'b1;
        2'b01:   bankCnt <= bankCnt - 1'b1;
        default: bankCnt <= bankCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
    end else if (strobe.clrPend) begin
      pend <= '0;
    end else if (decValid) begin
      pend <= pend | {slotNow, genNow, divNow, undfNow, trapNow};
    end
  end

  assign flags.slotIll  = pend[4];
  assign flags.genIll   = pend[3];
  assign flags.divErr   = pend[2];
  assign flags.bankUndf = pend[1];
  assign flags.trap     = pend[0];
  assign flags.bankOvf  = saveEv & bankFull & bankOvfEn;
endmodule

// File: rtl/excCtl.sv
module excCtl
  import excPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       porPin,
  input  logic       manPin,
  input  logic       dbgRstAssert,
  input  logic       dbgRstNegate,
  input  logic       wdtOvf,
  input  logic       wdtManual,
  input  logic       exIdle,
  input  dpFlags_t   flags,
  output ctlStrobe_t strobe,
  output logic       excReq,
  output logic [2:0] excCode
);
  logic porPrev, manPrev, dbgArmed;
  logic porHit, manHit, anyHit;
  logic [NUM_SRC-1:0] cand;
  logic [2:0] sel;

  assign porHit = (porPin & ~porPrev) | (dbgRstNegate & dbgArmed) | (wdtOvf & ~wdtManual);
  assign manHit = (manPin & ~manPrev) | (wdtOvf & wdtManual);

  assign cand[EXC_POR]  = porHit;
  assign cand[EXC_MAN]  = manHit;
  assign cand[EXC_SLOT] = flags.slotIll  & exIdle;
  assign cand[EXC_GEN]  = flags.genIll   & exIdle;
  assign cand[EXC_DIV]  = flags.divErr   & exIdle;
  assign cand[EXC_UNDF] = flags.bankUndf & exIdle;
  assign cand[EXC_OVF]  = flags.bankOvf;
  assign cand[EXC_TRAP] = flags.trap     & exIdle;

  assign anyHit = |cand;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) sel = 3'(i);
    end
  end

  assign strobe.clrBank = porHit | manHit;
  assign strobe.clrPend = anyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porPrev  <= 1'b1;
      manPrev  <= 1'b1;
      dbgArmed <= 1'b0;
      excReq   <= 1'b0;
      excCode  <= '0;
    end else begin
      porPrev  <= porPin;
      manPrev  <= manPin;
      dbgArmed <= porHit ? 1'b0 : (dbgArmed | dbgRstAssert);
      excReq   <= anyHit;
      excCode  <= anyHit ? sel : 3'd0;
    end
  end
endmodule

// File: rtl/excSourceUnit.sv
module excSourceUnit
  import excPkg::*;
#(
  parameter int NBANKS = 15,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          porPin,
  input  logic          manPin,
  input  logic          dbgRstAssert,
  input  logic          dbgRstNegate,
  input  logic          wdtOvf,
  input  logic          wdtManual,
  input  logic          exIdle,
  input  logic          decValid,
  input  logic          decInSlot,
  input  logic          decUndef,
  input  logic          decFpuOp,
  input  logic          fpuStandby,
  input  logic          decPcWrite,
  input  logic          decWide,
  input  logic          decBankRestore,
  input  logic          decDivS,
  input  logic          decDivU,
  input  logic          decTrap,
  input  logic [DW-1:0] divDividend,
  input  logic [DW-1:0] divDivisor,
  input  logic          bankOvfEn,
  input  logic          intAccept,
  input  logic          intUsesBank,
  output logic          excReq,
  output logic [2:0]    excCode
);
  dpFlags_t   dpFlags;
  ctlStrobe_t ctlStrobe;

  excDp #(.NBANKS(NBANKS), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(ctlStrobe),
    .decValid(decValid), .decInSlot(decInSlot), .decUndef(decUndef),
    .decFpuOp(decFpuOp), .fpuStandby(fpuStandby), .decPcWrite(decPcWrite),
    .decWide(decWide), .decBankRestore(decBankRestore), .decDivS(decDivS),
    .decDivU(decDivU), .decTrap(decTrap), .divDividend(divDividend),
    .divDivisor(divDivisor), .bankOvfEn(bankOvfEn), .intAccept(intAccept),
    .intUsesBank(intUsesBank), .flags(dpFlags)
  );

  excCtl u_ctl (
    .clk(clk), .rstN(rstN), .porPin(porPin), .manPin(manPin),
    .dbgRstAssert(dbgRstAssert), .dbgRstNegate(dbgRstNegate),
    .wdtOvf(wdtOvf), .wdtManual(wdtManual), .exIdle(exIdle),
    .flags(dpFlags), .strobe(ctlStrobe), .excReq(excReq), .excCode(excCode)
  );
endmodule

// File: rtl/excSourceChk.sv
module excSourceChk
  import excPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       porPin,
  input logic       manPin,
  input logic       dbgRstNegate,
  input logic       wdtOvf,
  input logic       exIdle,
  input logic       bankOvfEn,
  input logic       intAccept,
  input logic       intUsesBank,
  input dpFlags_t   dpFlags,
  input logic       excReq,
  input logic [2:0] excCode
);
  p_idle_code_r12: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |-> excCode == 3'd0);

  p_por_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && porPin && !$past(porPin) |=> excReq && excCode == 3'd0);

  p_man_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && manPin && !$past(manPin) && !porPin && !dbgRstNegate && !wdtOvf
      |=> excReq && excCode == 3'd1);

  p_ovf_cond_r5: assert property (@(posedge clk) disable iff (!rstN)
    dpFlags.bankOvf |-> bankOvfEn && intAccept && intUsesBank);

  p_wait_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    excReq && (excCode inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd7}) |-> $past(exIdle));
endmodule

bind excSourceUnit excSourceChk u_chk (
  .clk(clk), .rstN(rstN), .porPin(porPin), .manPin(manPin),
  .dbgRstNegate(dbgRstNegate), .wdtOvf(wdtOvf), .exIdle(exIdle),
  .bankOvfEn(bankOvfEn), .intAccept(intAccept), .intUsesBank(intUsesBank),
  .dpFlags(dpFlags), .excReq(excReq), .excCode(excCode)
);

// File: tb/tb_excSourceUnit.sv
`timescale 1ns/1ps
module tb_excSourceUnit;
  localparam int NB = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porPin = 0, manPin = 0, dbgRstAssert = 0, dbgRstNegate = 0;
  logic wdtOvf = 0, wdtManual = 0, exIdle = 1;
  logic decValid = 0, decInSlot = 0, decUndef = 0, decFpuOp = 0, fpuStandby = 0;
  logic decPcWrite = 0, decWide = 0, decBankRestore = 0, decDivS = 0, decDivU = 0, decTrap = 0;
  logic [31:0] divDividend = '0, divDivisor = '0;
  logic bankOvfEn = 0, intAccept = 0, intUsesBank = 0;
  logic excReq;
  logic [2:0] excCode;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  excSourceUnit dut (.*);

  typedef struct packed {
    logic slot, undef, fpuOp, fpuStd, pcw, wide, rest, divs, divu, trap;
    logic [31:0] a, b;
    logic expReq;
    logic [2:0] expCode;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{0,1,0,0,0,0,0,0,0,0, 32'h0, 32'h0, 1, 3'd3},            // R8 undefined
    '{0,0,1,1,0,0,0,0,0,0, 32'h0, 32'h0, 1, 3'd3},            // R8 fpu in standby
    '{0,0,1,0,0,0,0,0,0,0, 32'h0, 32'h0, 0, 3'd0},            // R8 fpu active
    '{1,1,0,0,0,0,0,0,0,0, 32'h0, 32'h0, 1, 3'd2},            // R7 undef in slot
    '{1,0,0,0,1,0,0,0,0,0, 32'h0, 32'h0, 1, 3'd2},            // R7 pc write
    '{1,0,0,0,0,1,0,0,0,0, 32'h0, 32'h0, 1, 3'd2},            // R7 wide
    '{1,0,0,0,0,0,1,0,0,0, 32'h0, 32'h0, 1, 3'd2},            // R7 restore
    '{1,0,0,0,0,0,0,1,0,0, 32'h9, 32'h5, 1, 3'd2},            // R7 divs
    '{0,0,0,0,0,0,0,0,1,0, 32'h7, 32'h0, 1, 3'd4},            // R9 zero divisor
    '{0,0,0,0,0,0,0,1,0,0, 32'h80000000, 32'hFFFFFFFF, 1, 3'd4}, // R9 overflow
    '{0,0,0,0,0,0,0,0,1,0, 32'h80000000, 32'hFFFFFFFF, 0, 3'd0}, // R9 unsigned ok
    '{0,0,0,0,0,0,0,1,0,0, 32'h80000000, 32'h2, 0, 3'd0},     // R9 plain divs
    '{0,0,0,0,0,0,0,0,0,1, 32'h0, 32'h0, 1, 3'd7},            // R10 trap
    '{0,0,0,0,0,0,1,0,0,0, 32'h0, 32'h0, 1, 3'd5},            // R6 underflow
    '{0,1,0,0,0,0,0,0,0,1, 32'h0, 32'h0, 1, 3'd3},            // R12 priority
    '{0,0,0,0,0,0,0,0,0,0, 32'h0, 32'h0, 0, 3'd0}             // nop
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic chkOut(input string tag, input logic r, input logic [2:0] c);
    chk({tag, " req"}, int'(excReq), int'(r));
    chk({tag, " code"}, int'(excCode), int'(c));
  endtask

  task automatic setDec(input vec_t v);
    decInSlot = v.slot; decUndef = v.undef; decFpuOp = v.fpuOp; fpuStandby = v.fpuStd;
    decPcWrite = v.pcw; decWide = v.wide; decBankRestore = v.rest; decDivS = v.divs;
    decDivU = v.divu; decTrap = v.trap; divDividend = v.a; divDivisor = v.b;
  endtask

  // drive one decode at a negedge, sample two edges later
  task automatic decodeOne(input vec_t v, input string tag);
    setDec(v); decValid = 1;
    @(negedge clk);
    decValid = 0; setDec('0);
    @(negedge clk);
    chkOut(tag, v.expReq, v.expCode);
  endtask

  task automatic bankSave(input logic en, input logic expR, input logic [2:0] expC, input string tag);
    intAccept = 1; intUsesBank = 1; bankOvfEn = en;
    @(negedge clk);
    intAccept = 0; intUsesBank = 0;
    chkOut(tag, expR, expC);
  endtask

  task automatic restore(input logic expR, input logic [2:0] expC, input string tag);
    vec_t v;
    v = '0; v.rest = 1; v.expReq = expR; v.expCode = expC;
    decodeOne(v, tag);
  endtask

  task automatic manPulse();
    manPin = 1;
    @(negedge clk);
    manPin = 0;
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog got=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chkOut("R12 reset state", 0, 0);

    for (int i = 0; i < NV; i++) begin
      decodeOne(VECS[i], $sformatf("vec%0d", i));
      @(negedge clk);
      chk("R12 pulse", int'(excReq), 0);
    end

    // R1 power-on pin
    porPin = 1; @(negedge clk); chkOut("R1 por edge", 1, 0);
    @(negedge clk); chk("R1 level no repeat", int'(excReq), 0);
    porPin = 0; @(negedge clk);

    // R2 debug commands
    dbgRstNegate = 1; @(negedge clk); dbgRstNegate = 0;
    chk("R2 negate alone", int'(excReq), 0);
    dbgRstAssert = 1; @(negedge clk); dbgRstAssert = 0;
    chk("R2 assert alone", int'(excReq), 0);
    @(negedge clk);
    dbgRstNegate = 1; @(negedge clk); dbgRstNegate = 0;
    chkOut("R2 assert then negate", 1, 0);
    dbgRstNegate = 1; @(negedge clk); dbgRstNegate = 0;
    chk("R2 second negate", int'(excReq), 0);

    // R3 manual pin
    manPin = 1; @(negedge clk); chkOut("R3 manual edge", 1, 1);
    manPin = 0; @(negedge clk);

    // R4 watchdog
    wdtOvf = 1; wdtManual = 0; @(negedge clk); wdtOvf = 0;
    chkOut("R4 wdt por", 1, 0);
    wdtOvf = 1; wdtManual = 1; @(negedge clk); wdtOvf = 0; wdtManual = 0;
    chkOut("R4 wdt manual", 1, 1);

    // R12 simultaneous resets
    porPin = 1; manPin = 1; @(negedge clk);
    chkOut("R12 por over man", 1, 0);
    porPin = 0; manPin = 0; @(negedge clk);

    // R11 wait for execute completion
    exIdle = 0;
    decTrap = 1; decValid = 1; @(negedge clk); decValid = 0; decTrap = 0;
    repeat (3) begin
      @(negedge clk); chk("R11 held while busy", int'(excReq), 0);
    end
    exIdle = 1; @(negedge clk);
    chkOut("R11 released", 1, 7);

    // R11 flush by a reset while waiting
    exIdle = 0;
    decUndef = 1; decValid = 1; @(negedge clk); decValid = 0; decUndef = 0;
    manPin = 1; @(negedge clk); manPin = 0;
    chkOut("R11 reset preempts", 1, 1);
    exIdle = 1; @(negedge clk); @(negedge clk);
    chk("R11 flushed", int'(excReq), 0);

    // R5 overflow and R6 depth
    for (int i = 0; i < NB; i++) bankSave(1, 0, 0, "R5 save below full");
    bankSave(1, 1, 6, "R5 overflow enabled");
    bankSave(0, 0, 0, "R5 overflow disabled");
    for (int i = 0; i < NB; i++) restore(0, 0, "R6 restore ok");
    restore(1, 5, "R6 underflow after drain");

    // R6 saturation
    for (int i = 0; i < NB + 2; i++) bankSave(0, 0, 0, "R6 saturating save");
    for (int i = 0; i < NB; i++) restore(0, 0, "R6 sat restore ok");
    restore(1, 5, "R6 saturated depth");

    // R6 reset clears depth
    bankSave(0, 0, 0, "R6 save a");
    bankSave(0, 0, 0, "R6 save b");
    manPulse();
    restore(1, 5, "R6 cleared by reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule